// File: doc/BRIEF.md
# Carry-Select Arithmetic and Logic Unit

This block is a 32-bit ALU that finishes one operation per clock. It serves data operations, memory address arithmetic and branch target sums. The arithmetic path is a carry-select adder. The word is split into 4-bit fields, and each field precomputes two sums: one for an incoming carry of 0 and one for an incoming carry of 1. A chain of field carries, each formed as generate OR (propagate AND incoming carry), steers a multiplexer in every field that picks the right sum.

A bitwise logic unit runs beside the adder, fed by the same operands. A final multiplexer chooses the arithmetic or the logic result by function class. The result and the four condition flags (negative, zero, carry, overflow) are captured in output registers on the rising clock edge. They are visible from that edge until the next one. Subtraction is formed as A + ~B + 1 and reverse subtraction as B + ~A + 1.

The block has no state machine. Its only state is the output register and the held carry and overflow flags.

Top module: `alu_csel_top`

## Requirements
- R1: Code 0 (add) yields A+B modulo 2^32. C is the carry out of bit 31, and V is set when A and B have the same sign and the result sign differs.
- R2: Code 1 (subtract) yields A-B modulo 2^32. C is 1 exactly when A >= B unsigned (no borrow), and V is set on signed overflow of A-B.
- R3: Code 2 (reverse subtract) yields B-A modulo 2^32. C is 1 exactly when B >= A unsigned, and V is set on signed overflow of B-A.
- R4: Code 3 (add with carry) yields A+B+cin modulo 2^32, with C the carry out of bit 31 and V the signed overflow of that sum.
- R5: Codes 4, 5, 6 and 7 yield A AND B, A OR B, A XOR B and A AND NOT B respectively.
- R6: Code 8 yields B and code 9 yields NOT B.
- R7: For every code other than 0 to 3, C and V keep the values they held before. Codes 10 to 15 are unused and yield a result of 0.
- R8: For every code, N equals bit 31 of the result and Z is 1 exactly when the result is all zeros.
- R9: Operands sampled at a rising edge appear on the result and flags from that edge on. While the active-high synchronous reset is asserted, the result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| cin_i | input | 1 | Carry input, used by add with carry |
| op_i | input | 4 | Function code |
| res_o | output | 32 | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
Several properties are checked on every cycle against the operands of the previous cycle:
- the add and AND results;
- N and Z tracking the result;
- C and V holding across every non-arithmetic code;
- the result being zero for unused codes;
- the cleared state in reset.

Only the bench's scenarios show the following:
- the carry and overflow values of subtract, reverse subtract and add with carry;
- carries that ripple through every field select, such as all-ones plus one;
- the signed overflow boundaries around 0x7FFFFFFF and 0x80000000.

// File: rtl/alu_csel_pkg.sv
package alu_csel_pkg;
    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_RSB = 4'd2,
        FN_ADC = 4'd3,
        FN_AND = 4'd4,
        FN_ORR = 4'd5,
        FN_EOR = 4'd6,
        FN_BIC = 4'd7,
        FN_MOV = 4'd8,
        FN_MVN = 4'd9
    } fn_e;

    function automatic logic fn_is_arith(input logic [3:0] code);
        return code[3:2] == 2'b00;
    endfunction
endpackage

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int WIDTH = 32,
    parameter int FIELD = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int NFIELD = WIDTH / FIELD;

    logic [NFIELD:0] carry;
    assign carry[0] = cin_i;

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        logic [FIELD-1:0] xf, yf;
        logic [FIELD:0]   sum_c0, sum_c1;
        logic             gen, prop;

        assign xf     = x_i[f*FIELD +: FIELD];
        assign yf     = y_i[f*FIELD +: FIELD];
        assign sum_c0 = {1'b0, xf} + {1'b0, yf};
        assign sum_c1 = {1'b0, xf} + {1'b0, yf} + {{FIELD{1'b0}}, 1'b1};
        assign gen    = sum_c0[FIELD];
        assign prop   = &(xf ^ yf);
        // field carry: generate, or propagate of the carry coming in
        assign carry[f+1] = gen | (prop & carry[f]);
        assign sum_o[f*FIELD +: FIELD] = carry[f] ? sum_c1[FIELD-1:0]
                                                  : sum_c0[FIELD-1:0];
    end

    assign cout_o = carry[NFIELD];
    assign ovf_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) &&
                    (sum_o[WIDTH-1] != x_i[WIDTH-1]);
endmodule

// File: rtl/logic_unit.sv
module logic_unit
    import alu_csel_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            FN_AND:  res_o = a_i & b_i;
            FN_ORR:  res_o = a_i | b_i;
            FN_EOR:  res_o = a_i ^ b_i;
            FN_BIC:  res_o = a_i & ~b_i;
            FN_MOV:  res_o = b_i;
            FN_MVN:  res_o = ~b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_csel_top.sv
module alu_csel_top
    import alu_csel_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FIELD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o
);
    logic [WIDTH-1:0] add_x, add_y, add_sum, log_res, res_d;
    logic             add_cin, add_cout, add_ovf, arith;

    // operand steering for the adder
    always_comb begin
        add_x   = a_i;
        add_y   = b_i;
        add_cin = 1'b0;
        unique case (op_i)
            FN_SUB: begin add_y = ~b_i; add_cin = 1'b1; end
            FN_RSB: begin add_x = b_i; add_y = ~a_i; add_cin = 1'b1; end
            FN_ADC: add_cin = cin_i;
            default: ;
        endcase
    end

    csel_adder #(.WIDTH(WIDTH), .FIELD(FIELD)) u_add (
        .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    logic_unit #(.WIDTH(WIDTH)) u_log (
        .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(log_res)
    );

    assign arith = fn_is_arith(op_i);
    assign res_d = arith ? add_sum : log_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
            n_o   <= 1'b0;
            z_o   <= 1'b0;
            c_o   <= 1'b0;
            v_o   <= 1'b0;
        end else begin
            res_o <= res_d;
            n_o   <= res_d[WIDTH-1];
            z_o   <= (res_d == '0);
            if (arith) begin
                c_o <= add_cout;
                v_o <= add_ovf;
            end
        end
    end
endmodule

// File: rtl/alu_csel_chk.sv
module alu_csel_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] res_o,
    input logic             n_o,
    input logic             z_o,
    input logic             c_o,
    input logic             v_o
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    logic arith_now;
    assign arith_now = (op_i[3:2] == 2'b00);

    p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) == 4'd0) |-> res_o == $past(a_i + b_i));

    p_and_res_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) == 4'd4) |-> res_o == $past(a_i & b_i));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !arith_now) |=> ($stable(c_o) && $stable(v_o)));

    p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) >= 4'd10) |-> res_o == '0);

    p_nz_track_r8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (n_o == res_o[WIDTH-1] && z_o == (res_o == '0)));

    p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (res_o == '0 && !n_o && !z_o && !c_o && !v_o));

    logic unused_ok;
    assign unused_ok = cin_i;
endmodule

bind alu_csel_top alu_csel_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i),
    .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
);

// File: tb/alu_csel_top_tb.sv
module alu_csel_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0, b = '0;
    logic        ci = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] res;
    logic        n, z, c, v;

    int total = 0;
    int bad   = 0;
    logic m_c = 1'b0, m_v = 1'b0;

    always #10 clk = ~clk;

    alu_csel_top u_dut (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(ci), .op_i(op),
        .res_o(res), .n_o(n), .z_o(z), .c_o(c), .v_o(v)
    );

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            default: return "R7";
        endcase
    endfunction

    // returns {res, c, v}
    function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic k, input logic [3:0] f,
                                          input logic hc, input logic hv);
        logic [32:0] t;
        logic [31:0] r;
        logic cc, vv;
        cc = hc; vv = hv; r = '0; t = '0;
        case (f)
            4'd0: begin t = {1'b0, x} + {1'b0, y};
                  vv = (x[31] == y[31]) && (t[31] != x[31]); end
            4'd1: begin t = {1'b0, x} + {1'b0, ~y} + 33'd1;
                  vv = (x[31] != y[31]) && (t[31] != x[31]); end
            4'd2: begin t = {1'b0, y} + {1'b0, ~x} + 33'd1;
                  vv = (x[31] != y[31]) && (t[31] != y[31]); end
            4'd3: begin t = {1'b0, x} + {1'b0, y} + {32'd0, k};
                  vv = (x[31] == y[31]) && (t[31] != x[31]); end
            4'd4: r = x & y;
            4'd5: r = x | y;
            4'd6: r = x ^ y;
            4'd7: r = x & ~y;
            4'd8: r = y;
            4'd9: r = ~y;
            default: r = '0;
        endcase
        if (f < 4'd4) begin r = t[31:0]; cc = t[32]; end
        return {r, cc, vv};
    endfunction

    task automatic check1(input string tg, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] x, input logic [31:0] y,
                       input logic k, input logic [3:0] f);
        logic [33:0] e;
        string tcv;
        @(negedge clk);
        a = x; b = y; ci = k; op = f;
        e = model(x, y, k, f, m_c, m_v);
        @(posedge clk);
        #1;
        check1(tag_of(f), "result", res, e[33:2]);
        tcv = (f < 4'd4) ? tag_of(f) : "R7";
        check1(tcv, "carry", {31'd0, c}, {31'd0, e[1]});
        check1(tcv, "overflow", {31'd0, v}, {31'd0, e[0]});
        check1("R8", "negative", {31'd0, n}, {31'd0, e[33]});
        check1("R8", "zero", {31'd0, z}, {31'd0, e[33:2] == 32'd0});
        m_c = e[1];
        m_v = e[0];
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check1("R9", "reset result", res, 32'd0);
        check1("R9", "reset flags", {28'd0, n, z, c, v}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        run(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'd0); // R1 carry through every field
        run(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'd0); // R1 signed overflow
        run(32'h8000_0000, 32'h8000_0000, 1'b0, 4'd0); // R1 carry and overflow
        run(32'h1234_5678, 32'h1234_5678, 1'b0, 4'd1); // R2 equal: zero, no borrow
        run(32'h0000_0000, 32'h0000_0001, 1'b0, 4'd1); // R2 borrow
        run(32'h8000_0000, 32'h0000_0001, 1'b0, 4'd1); // R2 overflow
        run(32'h0000_0005, 32'h0000_0003, 1'b0, 4'd2); // R3 negative result
        run(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 4'd3); // R4 carry-in ripples
        run(32'h7FFF_FFFE, 32'h0000_0001, 1'b1, 4'd3); // R4 overflow via carry-in
        run(32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 4'd7); // R5 bit clear, R7 hold
        run(32'h0000_0000, 32'h0000_0000, 1'b0, 4'd9); // R6 move-not
        run(32'hDEAD_BEEF, 32'h0000_0000, 1'b0, 4'd8); // R6 move zero -> Z
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd12); // R7 unused code
        run(32'h0000_0000, 32'h0000_0000, 1'b0, 4'd1); // R2 0-0 sets C
        run(32'h1111_1111, 32'h2222_2222, 1'b0, 4'd15); // R7 C held at 1

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x, y;
            logic [3:0]  f;
            int sel;
            sel = $urandom_range(0, 9);
            x = $urandom();
            y = $urandom();
            if (sel == 0) y = x;
            if (sel == 1) y = ~x;
            if (sel == 2) x = 32'h7FFF_FFFF ^ {31'd0, x[0]};
            f = (($urandom_range(0, 15) == 0) ? 4'($urandom_range(10, 15))
                                               : 4'($urandom_range(0, 9)));
            run(x, y, 1'($urandom_range(0, 1)), f);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule